// File: doc/BRIEF.md
# Bitmap-Compressed Automaton Next-State Unit

This unit advances a multi-pattern string-matching automaton by one input byte. Each automaton state lives in a state memory as one wide record. The record's transitions are compressed: a presence bitmap holds one bit for every possible byte value, and the successors of the set bits are stored back to back in a separate next-state table, starting at a base address that the record also holds. To follow a byte, the unit tests that byte's bit in the bitmap. It counts the set bits below that position to get the entry's rank within the compacted table, and reads the successor from the table.

When the byte has no transition, the unit walks the state's failure pointer and tries again. It repeats this until some state has the transition or the root is reached. At the root, a missing transition consumes the byte and the automaton stays at the root. Once the resulting state is known, its own record is fetched. The unit then reports that state together with a match flag, which is set when the state's match pointer is nonzero, and the state's info byte. A controller drives one request at a time with a start pulse and waits for the done pulse.

The bit count is done over a fixed number of chunk-wide slices, one slice per clock. This trades cycles for a small adder.

Top module: `bmnx_next_state`

## Requirements
- R1: While reset is high and in the first cycle after it, `done_o`, `match_o`, `st_rd_en_o` and `nt_rd_en_o` are low, and `next_state_o` and `state_info_o` are zero.
- R2: The state record is packed from the most significant end as bitmap (NSYM bits, bit b for byte value b), failure state, next-table base, match pointer, and info byte in the least significant bits. When bit `sym` of the current state's bitmap is set, the result is the next-table entry at base plus the number of set bits at positions strictly below `sym`. The lowest set byte therefore uses offset 0, and byte values 0 and NSYM-1 both work.
- R3: When the byte's bit is clear in a non-root state, that state is replaced by its failure state and the test repeats. This continues until a transition is found or the root is reached.
- R4: When the byte's bit is clear in the root state, the result is the root, the byte counts as consumed, and no next-table read is issued.
- R5: With the result, `match_o` is high exactly when the resulting state's match pointer is nonzero, and `state_info_o` carries that state's info byte. Both hold their values until the next result.
- R6: `done_o` is a one-cycle pulse per accepted start. The state and byte are sampled on the start cycle. A start raised while an operation is in progress is ignored and yields no extra result, and `next_state_o` changes only on a done cycle.
- R7: Counting the edge that samples start as 1, `done_o` is high after edge 3 + 2F, plus 13 more when a transition is found. F is the number of failure steps taken, and the 13 include NSYM/CHUNK_W counting cycles.
- R8: Every memory read request is a single-cycle pulse, and the state-memory and next-table requests are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one step when idle |
| sym_i | input | SYM_W | Input byte |
| state_i | input | STATE_W | Current automaton state |
| done_o | output | 1 | One-cycle result strobe |
| next_state_o | output | STATE_W | Resulting state |
| match_o | output | 1 | Resulting state has a nonzero match pointer |
| state_info_o | output | INFO_W | Info byte of the resulting state |
| st_rd_en_o | output | 1 | State memory read request |
| st_rd_addr_o | output | STATE_W | State memory read address (state number) |
| st_rd_data_i | input | REC_W | State record, valid the cycle after the request is sampled |
| nt_rd_en_o | output | 1 | Next-state table read request |
| nt_rd_addr_o | output | BASE_W | Next-state table read address |
| nt_rd_data_i | input | STATE_W | Next-state table entry, one cycle latency |

## Verification
The bench builds the unit with the full 256-value byte alphabet and a 32-bit chunk, so each count takes eight slices. This puts bits 0 and 255 of a bitmap into the first and last slices, and offsets 0 and 3 at the root are both reachable. State, base and match-pointer widths are narrowed to 8 bits, which keeps the record at 288 bits and the memories small. The test automaton has a state whose failure chain ends in a transition, a chain that runs out at the root, and a direct miss at the root, so the exact cycle counts of R7 are checked for zero, one and two failure steps.

// File: rtl/bmnx_pkg.sv
package bmnx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SWAIT = 3'd1,
    PH_SCAP  = 3'd2,
    PH_COUNT = 3'd3,
    PH_NWAIT = 3'd4,
    PH_NCAP  = 3'd5
  } bmnx_phase_e;

endpackage

// File: rtl/bmnx_lower_mask.sv
module bmnx_lower_mask #(
  parameter int SYM_W = 8,
  localparam int NSYM = 1 << SYM_W
) (
  input  logic [SYM_W-1:0] sym_i,
  input  logic [NSYM-1:0]  map_i,
  output logic             hit_o,
  output logic [NSYM-1:0]  below_o
);

  logic [NSYM-1:0] lower;

  // bit b of lower is set when b lies strictly below the input byte
  for (genvar b = 0; b < NSYM; b++) begin : g_lower
    assign lower[b] = (sym_i > SYM_W'(b));
  end

  assign hit_o   = map_i[sym_i];
  assign below_o = map_i & lower;

endmodule

// File: rtl/bmnx_chunk_count.sv
module bmnx_chunk_count #(
  parameter int WIDTH = 32,
  localparam int OUT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic [OUT_W-1:0] count_o
);

  always_comb begin
    count_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      count_o = count_o + OUT_W'(bits_i[i]);
    end
  end

endmodule

// File: rtl/bmnx_offset_engine.sv
module bmnx_offset_engine #(
  parameter int NSYM    = 256,
  parameter int CHUNK_W = 32,
  localparam int NCHUNK = NSYM / CHUNK_W,
  localparam int IDX_W  = (NCHUNK > 1) ? $clog2(NCHUNK) : 1,
  localparam int CNT_W  = $clog2(NSYM + 1),
  localparam int CC_W   = $clog2(CHUNK_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [NSYM-1:0]  vec_i,
  output logic             done_o,
  output logic [CNT_W-1:0] offset_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCHUNK - 1);

  logic [NSYM-1:0]    vec_q;
  logic [IDX_W-1:0]   idx_q;
  logic [CNT_W-1:0]   acc_q;
  logic               run_q;
  logic               done_q;
  logic [CNT_W-1:0]   off_q;
  logic [CHUNK_W-1:0] slice [NCHUNK];
  logic [CHUNK_W-1:0] cur_slice;
  logic [CC_W-1:0]    slice_cnt;
  logic [CNT_W-1:0]   acc_next;

  for (genvar c = 0; c < NCHUNK; c++) begin : g_slice
    assign slice[c] = vec_q[c*CHUNK_W +: CHUNK_W];
  end

  if (NCHUNK == 1) begin : g_single
    assign cur_slice = slice[0];
  end else begin : g_multi
    assign cur_slice = slice[idx_q];
  end

  bmnx_chunk_count #(.WIDTH(CHUNK_W)) u_count (
    .bits_i  (cur_slice),
    .count_o (slice_cnt)
  );

  assign acc_next = acc_q + CNT_W'(slice_cnt);

  always_ff @(posedge clk) begin
    if (load_i) begin
      vec_q <= vec_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      acc_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      off_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        idx_q <= '0;
        acc_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        acc_q <= acc_next;
        if (idx_q == LAST_IDX) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
          off_q  <= acc_next;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign done_o   = done_q;
  assign offset_o = off_q;

endmodule

// File: rtl/bmnx_next_state.sv
module bmnx_next_state
  import bmnx_pkg::*;
#(
  parameter int SYM_W      = 8,
  parameter int STATE_W    = 32,
  parameter int BASE_W     = 32,
  parameter int MPTR_W     = 32,
  parameter int INFO_W     = 8,
  parameter int CHUNK_W    = 32,
  parameter int ROOT_STATE = 0,
  localparam int NSYM  = 1 << SYM_W,
  localparam int REC_W = NSYM + STATE_W + BASE_W + MPTR_W + INFO_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [SYM_W-1:0]   sym_i,
  input  logic [STATE_W-1:0] state_i,
  output logic               done_o,
  output logic [STATE_W-1:0] next_state_o,
  output logic               match_o,
  output logic [INFO_W-1:0]  state_info_o,
  output logic               st_rd_en_o,
  output logic [STATE_W-1:0] st_rd_addr_o,
  input  logic [REC_W-1:0]   st_rd_data_i,
  output logic               nt_rd_en_o,
  output logic [BASE_W-1:0]  nt_rd_addr_o,
  input  logic [STATE_W-1:0] nt_rd_data_i
);

  localparam int CNT_W    = $clog2(NSYM + 1);
  localparam int MPTR_LSB = INFO_W;
  localparam int BASE_LSB = MPTR_LSB + MPTR_W;
  localparam int FAIL_LSB = BASE_LSB + BASE_W;
  localparam int MAP_LSB  = FAIL_LSB + STATE_W;
  localparam logic [STATE_W-1:0] ROOT = STATE_W'(ROOT_STATE);

  // record fields
  logic [NSYM-1:0]    rec_map;
  logic [STATE_W-1:0] rec_fail;
  logic [BASE_W-1:0]  rec_base;
  logic [MPTR_W-1:0]  rec_mptr;
  logic [INFO_W-1:0]  rec_info;

  assign rec_map  = st_rd_data_i[MAP_LSB  +: NSYM];
  assign rec_fail = st_rd_data_i[FAIL_LSB +: STATE_W];
  assign rec_base = st_rd_data_i[BASE_LSB +: BASE_W];
  assign rec_mptr = st_rd_data_i[MPTR_LSB +: MPTR_W];
  assign rec_info = st_rd_data_i[0 +: INFO_W];

  bmnx_phase_e        phase_q;
  logic [SYM_W-1:0]   sym_q;
  logic [STATE_W-1:0] cur_q;
  logic               final_q;
  logic [BASE_W-1:0]  base_q;
  logic               st_en_q;
  logic [STATE_W-1:0] st_addr_q;
  logic               nt_en_q;
  logic [BASE_W-1:0]  nt_addr_q;
  logic               done_q;
  logic [STATE_W-1:0] ns_q;
  logic               match_q;
  logic [INFO_W-1:0]  info_q;

  logic               sym_hit;
  logic [NSYM-1:0]    below_map;
  logic               eng_load;
  logic               eng_done;
  logic [CNT_W-1:0]   eng_off;

  bmnx_lower_mask #(.SYM_W(SYM_W)) u_mask (
    .sym_i   (sym_q),
    .map_i   (rec_map),
    .hit_o   (sym_hit),
    .below_o (below_map)
  );

  assign eng_load = (phase_q == PH_SCAP) && !final_q && sym_hit;

  bmnx_offset_engine #(.NSYM(NSYM), .CHUNK_W(CHUNK_W)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .load_i   (eng_load),
    .vec_i    (below_map),
    .done_o   (eng_done),
    .offset_o (eng_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      sym_q     <= '0;
      cur_q     <= '0;
      final_q   <= 1'b0;
      base_q    <= '0;
      st_en_q   <= 1'b0;
      st_addr_q <= '0;
      nt_en_q   <= 1'b0;
      nt_addr_q <= '0;
      done_q    <= 1'b0;
      ns_q      <= '0;
      match_q   <= 1'b0;
      info_q    <= '0;
    end else begin
      st_en_q <= 1'b0;
      nt_en_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            sym_q     <= sym_i;
            cur_q     <= state_i;
            final_q   <= 1'b0;
            st_en_q   <= 1'b1;
            st_addr_q <= state_i;
            phase_q   <= PH_SWAIT;
          end
        end
        PH_SWAIT: begin
          phase_q <= PH_SCAP;
        end
        PH_SCAP: begin
          if (final_q || (!sym_hit && cur_q == ROOT)) begin
            done_q  <= 1'b1;
            ns_q    <= final_q ? cur_q : ROOT;
            match_q <= |rec_mptr;
            info_q  <= rec_info;
            phase_q <= PH_IDLE;
          end else if (sym_hit) begin
            base_q  <= rec_base;
            phase_q <= PH_COUNT;
          end else begin
            cur_q     <= rec_fail;
            st_en_q   <= 1'b1;
            st_addr_q <= rec_fail;
            phase_q   <= PH_SWAIT;
          end
        end
        PH_COUNT: begin
          if (eng_done) begin
            nt_en_q   <= 1'b1;
            nt_addr_q <= base_q + BASE_W'(eng_off);
            phase_q   <= PH_NWAIT;
          end
        end
        PH_NWAIT: begin
          phase_q <= PH_NCAP;
        end
        PH_NCAP: begin
          cur_q     <= nt_rd_data_i;
          final_q   <= 1'b1;
          st_en_q   <= 1'b1;
          st_addr_q <= nt_rd_data_i;
          phase_q   <= PH_SWAIT;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign done_o       = done_q;
  assign next_state_o = ns_q;
  assign match_o      = match_q;
  assign state_info_o = info_q;
  assign st_rd_en_o   = st_en_q;
  assign st_rd_addr_o = st_addr_q;
  assign nt_rd_en_o   = nt_en_q;
  assign nt_rd_addr_o = nt_addr_q;

endmodule

// File: rtl/bmnx_next_state_chk.sv
module bmnx_next_state_chk #(
  parameter int STATE_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               done_o,
  input logic [STATE_W-1:0] next_state_o,
  input logic               match_o,
  input logic               st_rd_en_o,
  input logic               nt_rd_en_o
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!done_o && !st_rd_en_o && !nt_rd_en_o)); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R6

  AST_STATE_ON_DONE: assert property (@(posedge clk) disable iff (rst) !$stable(next_state_o) |-> done_o); // R6

  AST_MATCH_ON_DONE: assert property (@(posedge clk) disable iff (rst) !$stable(match_o) |-> done_o); // R5

  AST_ST_PULSE: assert property (@(posedge clk) disable iff (rst) st_rd_en_o |=> !st_rd_en_o); // R8

  AST_NT_PULSE: assert property (@(posedge clk) disable iff (rst) nt_rd_en_o |=> !nt_rd_en_o); // R8

  AST_RD_EXCL: assert property (@(posedge clk) disable iff (rst) !(st_rd_en_o && nt_rd_en_o)); // R8

endmodule

bind bmnx_next_state bmnx_next_state_chk #(.STATE_W(STATE_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .done_o       (done_o),
  .next_state_o (next_state_o),
  .match_o      (match_o),
  .st_rd_en_o   (st_rd_en_o),
  .nt_rd_en_o   (nt_rd_en_o)
);

// File: tb/test_bmnx_next_state.sv
module test_bmnx_next_state;

  localparam int SW    = 8;
  localparam int REC_W = 256 + 4 * SW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [7:0]       sym = '0;
  logic [SW-1:0]    cur = '0;
  logic             done;
  logic [SW-1:0]    next_state;
  logic             match;
  logic [7:0]       info;
  logic             st_en;
  logic [SW-1:0]    st_addr;
  logic [REC_W-1:0] st_data;
  logic             nt_en;
  logic [SW-1:0]    nt_addr;
  logic [SW-1:0]    nt_data;

  always #10 clk = ~clk;

  bmnx_next_state #(
    .SYM_W(8), .STATE_W(SW), .BASE_W(SW), .MPTR_W(SW), .INFO_W(8), .CHUNK_W(32), .ROOT_STATE(0)
  ) i_bmnx_next_state (
    .clk(clk), .rst(rst), .start_i(start), .sym_i(sym), .state_i(cur),
    .done_o(done), .next_state_o(next_state), .match_o(match), .state_info_o(info),
    .st_rd_en_o(st_en), .st_rd_addr_o(st_addr), .st_rd_data_i(st_data),
    .nt_rd_en_o(nt_en), .nt_rd_addr_o(nt_addr), .nt_rd_data_i(nt_data)
  );

  // automaton model tables
  logic [255:0]  bm   [8];
  logic [SW-1:0] fl   [8];
  logic [SW-1:0] bs   [8];
  logic [SW-1:0] mp   [8];
  logic [7:0]    inf  [8];
  logic [SW-1:0] ntab [16];

  always_ff @(posedge clk) begin
    if (st_en) st_data <= {bm[st_addr[2:0]], fl[st_addr[2:0]], bs[st_addr[2:0]], mp[st_addr[2:0]], inf[st_addr[2:0]]};
    if (nt_en) nt_data <= ntab[nt_addr[3:0]];
  end

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct packed {
    logic [SW-1:0] ns;
    logic          m;
    logic [7:0]    inf;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected done: actual state %0d expected no result", next_state);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (next_state !== e.ns || match !== e.m || info !== e.inf) begin
          errors++;
          $display("FAIL %s result: actual state %0d match %0b info %h expected state %0d match %0b info %h",
                   t, next_state, match, info, e.ns, e.m, e.inf);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors);
      $finish;
    end
  end

  task automatic add_state(input int s, input logic [SW-1:0] f, input logic [SW-1:0] b, input logic [SW-1:0] m);
    bm[s] = '0; fl[s] = f; bs[s] = b; mp[s] = m; inf[s] = 8'hA0 + 8'(s);
  endtask

  task automatic model(input logic [SW-1:0] c, input logic [7:0] y, output exp_t e, output int lat);
    logic [SW-1:0] s;
    logic [255:0]  lowmask;
    int off;
    bit fin;
    s = c; lat = 3; fin = 0;
    while (!fin) begin
      if (bm[s[2:0]][y]) begin
        lowmask = (256'(1) << y) - 256'(1);
        off = $countones(bm[s[2:0]] & lowmask);
        s = ntab[4'(int'(bs[s[2:0]]) + off)];
        lat += 13; fin = 1;
      end else if (s == 0) begin
        fin = 1;
      end else begin
        s = fl[s[2:0]]; lat += 2;
      end
    end
    e.ns = s; e.m = (mp[s[2:0]] != 0); e.inf = inf[s[2:0]];
  endtask

  task automatic run_op(input logic [SW-1:0] c, input logic [7:0] y, input string tag, input bit disturb);
    exp_t e;
    int exp_lat;
    int lat;
    model(c, y, e, exp_lat);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    cur = c; sym = y; start = 1'b1;
    lat = 0;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      start = 1'b0;
      cur = '0; sym = 8'hEE;
      if (disturb && lat == 5) begin
        start = 1'b1; cur = '0; sym = 8'h42;
      end
      if (done) break;
    end
    checks++;
    if (lat != exp_lat) begin
      errors++;
      $display("FAIL R7 latency for %s: actual %0d expected %0d", tag, lat, exp_lat);
    end
  endtask

  initial begin
    for (int s = 0; s < 8; s++) add_state(s, 0, 0, 0);
    for (int k = 0; k < 16; k++) ntab[k] = '0;
    // root: 00->7, 'A'->1, 'B'->3, FF->6
    bm[0][8'h00] = 1'b1; bm[0][8'h41] = 1'b1; bm[0][8'h42] = 1'b1; bm[0][8'hFF] = 1'b1;
    ntab[0] = 7; ntab[1] = 1; ntab[2] = 3; ntab[3] = 6;
    bm[1][8'h42] = 1'b1; bs[1] = 4; ntab[4] = 2;             // "A" -B-> "AB"
    bm[2][8'h44] = 1'b1; bs[2] = 5; ntab[5] = 5; fl[2] = 3;  // "AB" -D-> "ABD", fail "B"
    mp[2] = 1;
    bm[3][8'h43] = 1'b1; bs[3] = 6; ntab[6] = 4;             // "B" -C-> "BC"
    mp[4] = 2; mp[5] = 3;

    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || match !== 1'b0 || st_en !== 1'b0 || nt_en !== 1'b0 || next_state !== '0 || info !== '0) begin
      errors++;
      $display("FAIL R1 in reset: actual done %b match %b st %b nt %b state %0d expected all zero",
               done, match, st_en, nt_en, next_state);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || st_en !== 1'b0 || nt_en !== 1'b0 || next_state !== '0) begin
      errors++;
      $display("FAIL R1 after reset: actual done %b st %b nt %b state %0d expected zero", done, st_en, nt_en, next_state);
    end

    run_op(0, 8'h41, "R2 root hit A", 0);
    run_op(1, 8'h42, "R5 reach matching state", 0);
    run_op(2, 8'h44, "R5 direct hit to match", 0);
    run_op(0, 8'h00, "R2 byte 0 offset 0", 0);
    run_op(0, 8'hFF, "R2 byte 255 top slice", 0);
    run_op(0, 8'h42, "R2 middle offset", 0);
    run_op(2, 8'h43, "R3 one failure step then hit", 0);
    run_op(3, 8'h41, "R3 failure to root then hit", 0);
    run_op(2, 8'h5A, "R3 chain ends at root", 0);
    run_op(0, 8'h5A, "R4 root miss", 0);
    run_op(7, 8'h41, "R3 leaf failure to root", 0);
    run_op(0, 8'h41, "R6 start while busy ignored", 1);

    repeat (40) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6 pending results: actual %0d expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule